// File: doc/BRIEF.md
# Two-Level Segment/Page Address Translator

This block sits between a 32-bit processor and its memory system. Every access arrives with an 8-bit address-space identifier (ASI). The ASI decides whether the access is a lookup through the translation tables, a direct access to one of the two translation tables, an access to a small set of system control registers, or a boot-time instruction fetch that goes straight to ROM.

A translation works in two levels. The current context and the upper virtual-address bits select a segment-map entry, and that entry names a page-map group. The group number times 64, plus the page index from the virtual address, selects a page-table entry (PTE). A valid PTE with an accepted memory type produces a physical address and a target space, and the block sets the PTE's accessed bit. An invalid PTE, or one with a rejected type, gives a one-cycle fault instead, and no access takes place.

All lookups are combinational from the request. The result appears on a registered response one cycle later. Both map RAMs are built into the block and clear to zero on reset.

Top module: `mmu_seg_page`

## Requirements
- R1: While `rst` is high and after it falls, `rsp_valid`, `rsp_fault` and `diag_out` are 0. The context, system-enable and diagnostic registers read as 0, and every PTE is zero, so its valid bit is clear.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high, and is low otherwise. Data responses (`rsp_kind` 0) carry `rsp_paddr` 0, and any write response carries `rsp_rdata` 0.
- R3: With ASI 2, `req_addr[31:28]` picks a register. Select 3 is the context (CTX_W bits), select 4 is system enable, and select 7 is diagnostic. A write with `req_be[3]` set loads the register from `req_wdata[31:24]`, with the context masked to CTX_W bits. A read returns the value in `rsp_rdata[31:24]` with zeros below. The diagnostic register drives `diag_out`. Any other select reads 0, apart from select 8 (R4).
- R4: With ASI 2 and select 8, a tag store of 2^TAG_W words is indexed by `req_addr[TAG_W+1:2]`. Writes merge per byte lane, and reads return the stored word.
- R5: ASI 3 accesses the segment map at {context, `req_addr[18+SEG_W-1:18]`}, and each entry is 8 bits. With `req_be` 4'b1100, a write takes `req_wdata[23:16]` and a read returns the entry in bits [23:16]. With `req_be` 4'b1000, a write takes `req_wdata[31:24]`. Any other read returns the entry in bits [31:24]. A write with any other byte-enable pattern changes nothing.
- R6: ASI 4 accesses the PTE at index (segment entry[PMEG_W-1:0] × 64 + `req_addr[17:12]`). Writes merge per byte lane, and reads return the 32-bit PTE.
- R7: ASIs 8 to 11 translate the address. PTE bit 31 is the valid bit and bits [27:26] are the type. A valid PTE of type 0 gives `rsp_kind` 1, and type 1 gives `rsp_kind` 2. `rsp_paddr` is {4'b0, PTE[15:0], `req_addr[11:0]`}.
- R8: A translation that succeeds sets PTE bit 25 (accessed), which a later ASI 4 read can see.
- R9: A translation through a PTE with bit 31 clear raises `rsp_fault` for one cycle, with `rsp_kind` 0 and `rsp_paddr` 0. The PTE stays unchanged.
- R10: A valid PTE of type 2 or 3 also raises `rsp_fault`, and its accessed bit is not set.
- R11: While system-enable bit 7 is clear, an ASI 9 access gives `rsp_kind` 3 with `rsp_paddr` = `req_addr[ROM_AW-1:0]` zero-extended. When bit 7 is set, ASI 9 translates normally. Other translated ASIs always translate.
- R12: A translation uses the segment entries of the current context only, so a context switch changes which PTE is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_asi | input | 8 | Address-space identifier |
| req_addr | input | 32 | Virtual address / register select |
| req_we | input | 1 | Write when high |
| req_be | input | 4 | Byte-lane enables, bit 3 = bits [31:24] |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe |
| rsp_kind | output | 2 | 0 data, 1 device space 0, 2 device space 1, 3 boot ROM |
| rsp_paddr | output | 32 | Physical address |
| rsp_rdata | output | 32 | Read data for register and map reads |
| rsp_fault | output | 1 | Translation fault strobe |
| diag_out | output | 8 | Diagnostic register contents |

## Verification
Every response, fault and readback is due in the cycle that follows its request edge. Writes to registers and maps are visible to a request made in the next cycle. The bench drives each request on a falling edge and compares every response field on the next falling edge, which is exactly one rising edge later. Table writes are paired with later reads or translations, so the accessed-bit update and the writes that must be ignored are seen through the normal access path.

// File: rtl/mmu_pkg.sv
package mmu_pkg;

    localparam logic [7:0] ASI_SYS      = 8'd2;
    localparam logic [7:0] ASI_SEGMAP   = 8'd3;
    localparam logic [7:0] ASI_PAGEMAP  = 8'd4;
    localparam logic [7:0] ASI_XLAT_LO  = 8'd8;
    localparam logic [7:0] ASI_XLAT_HI  = 8'd11;
    localparam logic [7:0] ASI_SUP_INSN = 8'd9;

    localparam logic [3:0] SEL_CTX  = 4'd3;
    localparam logic [3:0] SEL_SYSEN = 4'd4;
    localparam logic [3:0] SEL_DIAG = 4'd7;
    localparam logic [3:0] SEL_TAG  = 4'd8;

    localparam int PTE_VALID_BIT = 31;
    localparam int PTE_ACC_BIT   = 25;
    localparam int PTE_TYPE_LSB  = 26;
    localparam int SYSEN_RUN_BIT = 7;
    localparam int PAGE_BITS     = 12;
    localparam int PAGE_IDX_W    = 6;
    localparam int SEG_LSB       = 18;

    typedef enum logic [1:0] {
        RK_DATA = 2'd0,
        RK_DEV0 = 2'd1,
        RK_DEV1 = 2'd2,
        RK_ROM  = 2'd3
    } rsp_kind_e;

    typedef struct packed {
        logic      valid;
        rsp_kind_e kind;
        logic [31:0] paddr;
        logic [31:0] rdata;
        logic      fault;
    } mmu_rsp_t;

    function automatic logic [31:0] frame_paddr(input logic [31:0] pte,
                                                input logic [31:0] va);
        return {4'b0, pte[15:0], va[PAGE_BITS-1:0]};
    endfunction

    function automatic logic [31:0] lane_merge(input logic [31:0] old_w,
                                               input logic [31:0] new_w,
                                               input logic [3:0]  be);
        logic [31:0] r;
        for (int i = 0; i < 4; i++)
            r[8*i +: 8] = be[i] ? new_w[8*i +: 8] : old_w[8*i +: 8];
        return r;
    endfunction

endpackage

// File: rtl/mmu_sysregs.sv
module mmu_sysregs
    import mmu_pkg::*;
#(
    parameter int CTX_W = 3,
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [3:0]       sel,
    input  logic [TAG_W-1:0] tag_idx,
    input  logic [3:0]       be,
    input  logic [31:0]      wdata,
    output logic [CTX_W-1:0] ctx,
    output logic [7:0]       sysen,
    output logic [7:0]       diag,
    output logic [31:0]      rdata
);
    localparam int TAG_N = 1 << TAG_W;

    logic [31:0] tags [TAG_N];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx   <= '0;
            sysen <= '0;
            diag  <= '0;
            for (int i = 0; i < TAG_N; i++) tags[i] <= '0;
        end else if (wr_en) begin
            if (be[3]) begin
                if (sel == SEL_CTX)   ctx   <= wdata[24 +: CTX_W];
                if (sel == SEL_SYSEN) sysen <= wdata[31:24];
                if (sel == SEL_DIAG)  diag  <= wdata[31:24];
            end
            if (sel == SEL_TAG)
                tags[tag_idx] <= lane_merge(tags[tag_idx], wdata, be);
        end
    end

    always_comb begin
        unique case (sel)
            SEL_CTX:   rdata = {8'(ctx), 24'b0};
            SEL_SYSEN: rdata = {sysen, 24'b0};
            SEL_DIAG:  rdata = {diag, 24'b0};
            SEL_TAG:   rdata = tags[tag_idx];
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/mmu_segmap.sv
module mmu_segmap
    import mmu_pkg::*;
#(
    parameter int CTX_W = 3,
    parameter int SEG_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CTX_W-1:0] ctx,
    input  logic [SEG_W-1:0] seg,
    input  logic             wr_en,
    input  logic [7:0]       wr_grp,
    output logic [7:0]       rd_grp
);
    localparam int IDX_W = CTX_W + SEG_W;
    localparam int DEPTH = 1 << IDX_W;

    logic [7:0]       entries [DEPTH];
    logic [IDX_W-1:0] idx;

    assign idx    = {ctx, seg};
    assign rd_grp = entries[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) entries[i] <= '0;
        end else if (wr_en) begin
            entries[idx] <= wr_grp;
        end
    end
endmodule

// File: rtl/mmu_pagemap.sv
module mmu_pagemap
    import mmu_pkg::*;
#(
    parameter int PMEG_W = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [PMEG_W+PAGE_IDX_W-1:0] idx,
    input  logic                         wr_en,
    input  logic [3:0]                   be,
    input  logic [31:0]                  wdata,
    input  logic                         set_acc,
    output logic [31:0]                  rd_pte
);
    localparam int DEPTH = 1 << (PMEG_W + PAGE_IDX_W);

    logic [31:0] ptes [DEPTH];

    assign rd_pte = ptes[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ptes[i] <= '0;
        end else if (wr_en) begin
            ptes[idx] <= lane_merge(ptes[idx], wdata, be);
        end else if (set_acc) begin
            ptes[idx][PTE_ACC_BIT] <= 1'b1;
        end
    end
endmodule

// File: rtl/mmu_seg_page.sv
module mmu_seg_page
    import mmu_pkg::*;
#(
    parameter int CTX_W  = 3,
    parameter int SEG_W  = 4,
    parameter int PMEG_W = 4,
    parameter int TAG_W  = 4,
    parameter int ROM_AW = 19
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [7:0]  req_asi,
    input  logic [31:0] req_addr,
    input  logic        req_we,
    input  logic [3:0]  req_be,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [1:0]  rsp_kind,
    output logic [31:0] rsp_paddr,
    output logic [31:0] rsp_rdata,
    output logic        rsp_fault,
    output logic [7:0]  diag_out
);
    localparam int PM_IDX_W = PMEG_W + PAGE_IDX_W;

    logic [CTX_W-1:0]    ctx;
    logic [7:0]          sysen;
    logic [31:0]         sys_rdata;
    logic [7:0]          seg_grp;
    logic [7:0]          seg_wr_grp;
    logic [31:0]         pte;
    logic [PM_IDX_W-1:0] pm_idx;
    logic                is_sys, is_seg, is_pm, is_xlat, boot_fetch;
    logic                seg_be_half, seg_be_byte;
    logic                sys_wr, seg_wr, pm_wr, acc_set;
    logic                pte_valid, type_ok;
    mmu_rsp_t            rsp_d, rsp_q;

    assign is_sys      = (req_asi == ASI_SYS);
    assign is_seg      = (req_asi == ASI_SEGMAP);
    assign is_pm       = (req_asi == ASI_PAGEMAP);
    assign is_xlat     = (req_asi >= ASI_XLAT_LO) && (req_asi <= ASI_XLAT_HI);
    assign boot_fetch  = !sysen[SYSEN_RUN_BIT] && (req_asi == ASI_SUP_INSN);
    assign seg_be_half = (req_be == 4'b1100);
    assign seg_be_byte = (req_be == 4'b1000);
    assign seg_wr_grp  = seg_be_half ? req_wdata[23:16] : req_wdata[31:24];

    assign sys_wr = req_valid && req_we && is_sys;
    assign seg_wr = req_valid && req_we && is_seg && (seg_be_half || seg_be_byte);
    assign pm_wr  = req_valid && req_we && is_pm;

    assign pm_idx    = {seg_grp[PMEG_W-1:0], req_addr[PAGE_BITS +: PAGE_IDX_W]};
    assign pte_valid = pte[PTE_VALID_BIT];
    assign type_ok   = !pte[PTE_TYPE_LSB+1];
    assign acc_set   = req_valid && is_xlat && !boot_fetch && pte_valid && type_ok;

    mmu_sysregs #(.CTX_W(CTX_W), .TAG_W(TAG_W)) u_sysregs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (sys_wr),
        .sel     (req_addr[31:28]),
        .tag_idx (req_addr[2 +: TAG_W]),
        .be      (req_be),
        .wdata   (req_wdata),
        .ctx     (ctx),
        .sysen   (sysen),
        .diag    (diag_out),
        .rdata   (sys_rdata)
    );

    mmu_segmap #(.CTX_W(CTX_W), .SEG_W(SEG_W)) u_segmap (
        .clk    (clk),
        .rst    (rst),
        .ctx    (ctx),
        .seg    (req_addr[SEG_LSB +: SEG_W]),
        .wr_en  (seg_wr),
        .wr_grp (seg_wr_grp),
        .rd_grp (seg_grp)
    );

    mmu_pagemap #(.PMEG_W(PMEG_W)) u_pagemap (
        .clk     (clk),
        .rst     (rst),
        .idx     (pm_idx),
        .wr_en   (pm_wr),
        .be      (req_be),
        .wdata   (req_wdata),
        .set_acc (acc_set),
        .rd_pte  (pte)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        rsp_d.kind  = RK_DATA;
        if (req_valid) begin
            if (boot_fetch) begin
                rsp_d.kind  = RK_ROM;
                rsp_d.paddr = 32'(req_addr[ROM_AW-1:0]);
            end else if (is_xlat) begin
                if (pte_valid && type_ok) begin
                    rsp_d.kind  = pte[PTE_TYPE_LSB] ? RK_DEV1 : RK_DEV0;
                    rsp_d.paddr = frame_paddr(pte, req_addr);
                end else begin
                    rsp_d.fault = 1'b1;
                end
            end else if (!req_we) begin
                if (is_sys)
                    rsp_d.rdata = sys_rdata;
                else if (is_seg)
                    rsp_d.rdata = seg_be_half ? {8'b0, seg_grp, 16'b0}
                                              : {seg_grp, 24'b0};
                else if (is_pm)
                    rsp_d.rdata = pte;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rsp_q <= '0;
        else     rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_kind  = rsp_q.kind;
    assign rsp_paddr = rsp_q.paddr;
    assign rsp_rdata = rsp_q.rdata;
    assign rsp_fault = rsp_q.fault;
endmodule

// File: rtl/mmu_seg_page_chk.sv
module mmu_seg_page_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [7:0]  req_asi,
    input logic [31:0] req_addr,
    input logic        req_we,
    input logic        rsp_valid,
    input logic [1:0]  rsp_kind,
    input logic [31:0] rsp_paddr,
    input logic        rsp_fault,
    input logic [7:0]  diag_out
);
    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R2
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid); // R2
    AST_FAULT_SHAPE: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> rsp_valid && rsp_kind == 2'd0 && rsp_paddr == 32'd0); // R9
    AST_FAULT_FROM_XLAT: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> $past(req_asi) >= 8'd8 && $past(req_asi) <= 8'd11); // R10
    AST_DEV_OFFSET: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && (rsp_kind == 2'd1 || rsp_kind == 2'd2)) |->
            $past(req_asi) >= 8'd8 && $past(req_asi) <= 8'd11 &&
            rsp_paddr[11:0] == $past(req_addr[11:0])); // R7
    AST_ROM_FETCH: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_kind == 2'd3) |->
            $past(req_asi) == 8'd9 && rsp_paddr[11:0] == $past(req_addr[11:0])); // R11
    AST_DIAG_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
        !$stable(diag_out) |->
            $past(req_valid && req_we && req_asi == 8'd2 && req_addr[31:28] == 4'd7)); // R3
endmodule

bind mmu_seg_page mmu_seg_page_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_asi   (req_asi),
    .req_addr  (req_addr),
    .req_we    (req_we),
    .rsp_valid (rsp_valid),
    .rsp_kind  (rsp_kind),
    .rsp_paddr (rsp_paddr),
    .rsp_fault (rsp_fault),
    .diag_out  (diag_out)
);

// File: tb/mmu_seg_page_test.sv
`timescale 1ns/1ps
module mmu_seg_page_test;

    typedef struct packed {
        logic [7:0]  asi;
        logic [31:0] addr;
        logic        we;
        logic [3:0]  be;
        logic [31:0] wdata;
        logic [1:0]  kind;
        logic [31:0] paddr;
        logic [31:0] rdata;
        logic        fault;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 37;
    localparam vec_t VEC [NV] = '{
        '{8'd2, 32'h4000_0000, 1'b1, 4'hF, 32'h8000_0000, 2'd0, 32'h0, 32'h0, 1'b0, 8'd3},  // R3 run mode
        '{8'd2, 32'h4000_0000, 1'b0, 4'hF, 32'h0,         2'd0, 32'h0, 32'h8000_0000, 1'b0, 8'd3},  // R3
        '{8'd2, 32'h3000_0000, 1'b1, 4'h8, 32'h02FF_FFFF, 2'd0, 32'h0, 32'h0, 1'b0, 8'd3},  // R3 ctx 2
        '{8'd2, 32'h3000_0000, 1'b0, 4'hF, 32'h0,         2'd0, 32'h0, 32'h0200_0000, 1'b0, 8'd3},
        '{8'd3, 32'h0004_0000, 1'b1, 4'h8, 32'h0500_0000, 2'd0, 32'h0, 32'h0, 1'b0, 8'd5},  // R5 seg1 -> 5
        '{8'd3, 32'h0004_0000, 1'b0, 4'hF, 32'h0,         2'd0, 32'h0, 32'h0500_0000, 1'b0, 8'd5},
        '{8'd4, 32'h0004_3000, 1'b1, 4'hF, 32'h8000_1234, 2'd0, 32'h0, 32'h0, 1'b0, 8'd6},  // R6
        '{8'd4, 32'h0004_3000, 1'b0, 4'hF, 32'h0,         2'd0, 32'h0, 32'h8000_1234, 1'b0, 8'd6},
        '{8'd8, 32'h0004_3ABC, 1'b0, 4'hF, 32'h0,         2'd1, 32'h0123_4ABC, 32'h0, 1'b0, 8'd7},  // R7
        '{8'd4, 32'h0004_3000, 1'b0, 4'hF, 32'h0,         2'd0, 32'h0, 32'h8200_1234, 1'b0, 8'd8},  // R8
        '{8'd4, 32'h0004_4000, 1'b1, 4'hF, 32'h8400_00FF, 2'd0, 32'h0, 32'h0, 1'b0, 8'd6},
        '{8'd10, 32'h0004_4010, 1'b0, 4'hF, 32'h0,        2'd2, 32'h000F_F010, 32'h0, 1'b0, 8'd7},  // R7 type 1
        '{8'd8, 32'h0004_5000, 1'b0, 4'hF, 32'h0,         2'd0, 32'h0, 32'h0, 1'b1, 8'd9},  // R9
        '{8'd4, 32'h0004_5000, 1'b0, 4'hF, 32'h0,         2'd0, 32'h0, 32'h0, 1'b0, 8'd9},  // R9 unchanged
        '{8'd4, 32'h0004_6000, 1'b1, 4'hF, 32'h8800_0777, 2'd0, 32'h0, 32'h0, 1'b0, 8'd10},
        '{8'd11, 32'h0004_6000, 1'b0, 4'hF, 32'h0,        2'd0, 32'h0, 32'h0, 1'b1, 8'd10}, // R10
        '{8'd4, 32'h0004_6000, 1'b0, 4'hF, 32'h0,         2'd0, 32'h0, 32'h8800_0777, 1'b0, 8'd10},
        '{8'd4, 32'h0004_6000, 1'b1, 4'h1, 32'h0000_00AA, 2'd0, 32'h0, 32'h0, 1'b0, 8'd6},  // R6 lane
        '{8'd4, 32'h0004_6000, 1'b0, 4'hF, 32'h0,         2'd0, 32'h0, 32'h8800_07AA, 1'b0, 8'd6},
        '{8'd3, 32'h0008_0000, 1'b1, 4'hC, 32'h0007_0000, 2'd0, 32'h0, 32'h0, 1'b0, 8'd5},  // R5 half
        '{8'd3, 32'h0008_0000, 1'b0, 4'hC, 32'h0,         2'd0, 32'h0, 32'h0007_0000, 1'b0, 8'd5},
        '{8'd3, 32'h0008_0000, 1'b0, 4'hF, 32'h0,         2'd0, 32'h0, 32'h0700_0000, 1'b0, 8'd5},
        '{8'd3, 32'h0008_0000, 1'b1, 4'h3, 32'h0000_FFFF, 2'd0, 32'h0, 32'h0, 1'b0, 8'd5},  // R5 ignored
        '{8'd3, 32'h0008_0000, 1'b0, 4'hF, 32'h0,         2'd0, 32'h0, 32'h0700_0000, 1'b0, 8'd5},
        '{8'd2, 32'h3000_0000, 1'b1, 4'h8, 32'h0000_0000, 2'd0, 32'h0, 32'h0, 1'b0, 8'd12}, // R12 ctx 0
        '{8'd8, 32'h0004_3ABC, 1'b0, 4'hF, 32'h0,         2'd0, 32'h0, 32'h0, 1'b1, 8'd12},
        '{8'd2, 32'h8000_0008, 1'b1, 4'hF, 32'hDEAD_BEEF, 2'd0, 32'h0, 32'h0, 1'b0, 8'd4},  // R4
        '{8'd2, 32'h8000_0008, 1'b0, 4'hF, 32'h0,         2'd0, 32'h0, 32'hDEAD_BEEF, 1'b0, 8'd4},
        '{8'd2, 32'h8000_000C, 1'b0, 4'hF, 32'h0,         2'd0, 32'h0, 32'h0, 1'b0, 8'd4},
        '{8'd2, 32'h7000_0000, 1'b1, 4'hF, 32'hA500_0000, 2'd0, 32'h0, 32'h0, 1'b0, 8'd3},  // R3 diag
        '{8'd2, 32'h7000_0000, 1'b0, 4'hF, 32'h0,         2'd0, 32'h0, 32'hA500_0000, 1'b0, 8'd3},
        '{8'd2, 32'h5000_0000, 1'b0, 4'hF, 32'h0,         2'd0, 32'h0, 32'h0, 1'b0, 8'd3},
        '{8'd2, 32'h4000_0000, 1'b1, 4'hF, 32'h0000_0000, 2'd0, 32'h0, 32'h0, 1'b0, 8'd11}, // R11 boot
        '{8'd9, 32'h00F1_2344, 1'b0, 4'hF, 32'h0,         2'd3, 32'h0001_2344, 32'h0, 1'b0, 8'd11},
        '{8'd2, 32'h3000_0000, 1'b1, 4'h8, 32'h0A00_0000, 2'd0, 32'h0, 32'h0, 1'b0, 8'd12}, // R12 mask
        '{8'd2, 32'h3000_0000, 1'b0, 4'hF, 32'h0,         2'd0, 32'h0, 32'h0200_0000, 1'b0, 8'd12},
        '{8'd8, 32'h0004_3ABC, 1'b0, 4'hF, 32'h0,         2'd1, 32'h0123_4ABC, 32'h0, 1'b0, 8'd11}  // R11 ASI 8
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [7:0]  req_asi = '0;
    logic [31:0] req_addr = '0;
    logic        req_we = 1'b0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_kind;
    logic [31:0] rsp_paddr;
    logic [31:0] rsp_rdata;
    logic        rsp_fault;
    logic [7:0]  diag_out;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    mmu_seg_page uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_asi(req_asi),
        .req_addr(req_addr), .req_we(req_we), .req_be(req_be),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
        .rsp_paddr(rsp_paddr), .rsp_rdata(rsp_rdata), .rsp_fault(rsp_fault),
        .diag_out(diag_out)
    );

    task automatic check(input bit ok, input int req, input logic [71:0] act,
                         input logic [71:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        logic [71:0] act, exp;
        @(negedge clk);
        req_valid = 1'b1; req_asi = v.asi; req_addr = v.addr;
        req_we = v.we; req_be = v.be; req_wdata = v.wdata;
        @(negedge clk);
        req_valid = 1'b0;
        act = {1'b0, rsp_valid, rsp_kind, rsp_fault, 3'b0, rsp_paddr, rsp_rdata};
        exp = {1'b0, 1'b1, v.kind, v.fault, 3'b0, v.paddr, v.rdata};
        check(act == exp, int'(v.req), act, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(rsp_valid == 1'b0 && rsp_fault == 1'b0 && diag_out == 8'h00, 1, // R1
              {62'b0, rsp_valid, rsp_fault, diag_out}, 72'h0);
        rst = 1'b0;
        @(negedge clk);
        check(rsp_valid == 1'b0 && diag_out == 8'h00, 1, // R1 after release
              {63'b0, rsp_valid, diag_out}, 72'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R2 actual=watchdog expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R2: an idle cycle gives no response
        @(negedge clk);
        check(rsp_valid == 1'b0, 2, {71'b0, rsp_valid}, 72'h0);
        // R3: diagnostic register reaches its output pin
        check(diag_out == 8'hA5, 3, {64'b0, diag_out}, {64'b0, 8'hA5});

        // R1: reset in mid-run clears registers and tables
        do_reset();
        run_vec('{8'd2, 32'h4000_0000, 1'b0, 4'hF, 32'h0, 2'd0, 32'h0, 32'h0, 1'b0, 8'd1});
        run_vec('{8'd2, 32'h3000_0000, 1'b0, 4'hF, 32'h0, 2'd0, 32'h0, 32'h0, 1'b0, 8'd1});
        run_vec('{8'd8, 32'h0004_3ABC, 1'b0, 4'hF, 32'h0, 2'd0, 32'h0, 32'h0, 1'b1, 8'd1});
        // R11: boot state after reset sends ASI 9 to ROM
        run_vec('{8'd9, 32'h0000_0100, 1'b0, 4'hF, 32'h0, 2'd3, 32'h0000_0100, 32'h0, 1'b0, 8'd11});
        // R9: fault is a single-cycle strobe
        @(negedge clk);
        check(rsp_fault == 1'b0 && rsp_valid == 1'b0, 9, {70'b0, rsp_valid, rsp_fault}, 72'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule